// File: doc/BRIEF.md
# Stack-to-Flags Write Permission Unit

This block holds the 64-bit processor flags register and updates it from a value popped off the stack. The popped value does not simply overwrite the register. Each flag bit gets its own write enable, and that enable depends on three things:

- the operating mode (real-address, protected or 64-bit, or virtual-8086);
- the effective operand size;
- how the current privilege level (CPL) compares with the I/O privilege field held in the register.

In virtual-8086 mode with a low I/O privilege, the pop is allowed only when the virtual-mode extension is on and the operand is 16 bits. On that path the stacked interrupt-enable bit goes into the virtual interrupt flag instead of the real one. Some stacked values are refused with a general-protection fault. A faulting pop leaves every flag untouched.

The execution pipeline pulses `pop_vld` with the popped data and the current mode inputs. The register and the fault pulse change on the next clock edge. The pending-virtual-interrupt indication reaches the block on `vint_pend`, from the logic that owns it. This block does not write that bit from the stack.

Top module: `flagpop_unit`

## Requirements
- R1: A synchronous active-low reset loads the flags value 0x2 and clears `gp_fault`.
- R2: The flags and `gp_fault` change only on the clock edge after `pop_vld` is high. While `pop_vld` is low the flags hold, whatever the other inputs do.
- R3: In real-address mode (`prot_en`=0), or at CPL 0 outside virtual-8086 mode, the loadable flags are taken from the popped value. The loadable flags are CF 0, PF 2, AF 4, ZF 6, SF 7, TF 8, IF 9, DF 10, OF 11, IOPL 13:12, NT 14, AC 18 and ID 21.
- R4: A 16-bit pop writes only bits 15:0. AC (18) and ID (21) therefore change only on 32- or 64-bit pops.
- R5: In protected or 64-bit mode with CPL > 0, IOPL (13:12) is never written. IF (9) is written only when CPL <= IOPL; otherwise IF keeps its value and no fault is raised.
- R6: In virtual-8086 mode with IOPL = 3, all loadable flags except IOPL are taken from the popped value, and no fault is raised.
- R7: In virtual-8086 mode with IOPL < 3, a pop with a 32-bit effective size, or with `vme_en`=0, raises `gp_fault` and leaves all flags unchanged.
- R8: In virtual-8086 mode with IOPL < 3, a 16-bit size and `vme_en`=1, a fault with no update occurs in two cases: stacked bit 8 is 1, or `vint_pend` is 1 and stacked bit 9 is 1.
- R9: On that extension path without a fault, VIF (19) takes stacked bit 9. Bits 15:0 are loaded, except IOPL and IF, which are kept.
- R10: RF (16) is 0 after every update. VIP (20) and VM (17) never change. Bit 1 always reads 1, and bits 3, 5, 15 and 22 to 63 always read 0.
- R11: `op_size` encodes 0 as 16-bit, 1 as 32-bit and 2 as 64-bit. A value of 3, or 2 outside 64-bit mode (`long_mode`=0, or not protected, or virtual-8086), acts as 32-bit.
- R12: `gp_fault` is high for exactly the cycle after a faulting pop and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pop_vld | input | 1 | A popped value is presented this cycle |
| pop_data | input | 64 | Value taken from the stack |
| op_size | input | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 bit |
| prot_en | input | 1 | Protection enabled (0 = real-address mode) |
| v86_mode | input | 1 | Virtual-8086 mode active |
| long_mode | input | 1 | 64-bit mode active |
| vme_en | input | 1 | Virtual-mode extension enable |
| vint_pend | input | 1 | Pending virtual interrupt indication |
| cpl | input | 2 | Current privilege level |
| flags | output | 64 | Registered flags value |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |

## Verification
The table walks a single chain of pops, so each result depends on the IOPL and IF values that earlier pops left behind.

- **All-ones and all-zeros pops** at each mode and size show which bits each permission row can reach.
- **Single-bit pops of bit 9** tell whether IF is enabled by the CPL-to-IOPL comparison.
- **Pops with bit 8 set, or with bit 9 set while `vint_pend` is high,** separate the two refusal conditions of the extension path from the clean path, where only VIF moves.
- **Oversized and illegal size codes in the wrong mode** show whether the size remapping changes a load into a fault.

// File: rtl/flagpop_pkg.sv
// Package: shared constants and types of the stack-to-flags unit.
// Assumes a 64-bit flags register with the architectural bit positions.
package flagpop_pkg;

    localparam int FLAGS_W = 64;
    localparam int CPL_W   = 2;
    localparam int NARROW_W = 16;

    // Architectural flag bit positions
    localparam int B_CF   = 0;
    localparam int B_ONE  = 1;
    localparam int B_PF   = 2;
    localparam int B_AF   = 4;
    localparam int B_ZF   = 6;
    localparam int B_SF   = 7;
    localparam int B_TF   = 8;
    localparam int B_IF   = 9;
    localparam int B_DF   = 10;
    localparam int B_OF   = 11;
    localparam int B_IOPL = 12;
    localparam int B_NT   = 14;
    localparam int B_RF   = 16;
    localparam int B_VM   = 17;
    localparam int B_AC   = 18;
    localparam int B_VIF  = 19;
    localparam int B_VIP  = 20;
    localparam int B_ID   = 21;

    typedef logic [FLAGS_W-1:0] flags_t;

    // Bits a pop may ever take from the stack
    localparam flags_t LOADABLE_M = flags_t'(
        (64'd1 << B_CF) | (64'd1 << B_PF) | (64'd1 << B_AF) | (64'd1 << B_ZF) |
        (64'd1 << B_SF) | (64'd1 << B_TF) | (64'd1 << B_IF) | (64'd1 << B_DF) |
        (64'd1 << B_OF) | (64'd3 << B_IOPL) | (64'd1 << B_NT) |
        (64'd1 << B_AC) | (64'd1 << B_ID));
    localparam flags_t IOPL_M   = flags_t'(64'd3 << B_IOPL);
    localparam flags_t IF_M     = flags_t'(64'd1 << B_IF);
    localparam flags_t NARROW_M = flags_t'((64'd1 << NARROW_W) - 64'd1);
    // Bits that physically exist as state (loadable plus RF, VM, VIF, VIP)
    localparam flags_t STATE_M  = LOADABLE_M | flags_t'(
        (64'd1 << B_RF) | (64'd1 << B_VM) | (64'd1 << B_VIF) | (64'd1 << B_VIP));
    localparam flags_t ONES_M   = flags_t'(64'd1 << B_ONE);
    localparam flags_t RESET_V  = ONES_M;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ32 = 2'd1,
        SZ64 = 2'd2
    } opsz_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2
    } mode_e;

endpackage

// File: rtl/flagpop_mode_decode.sv
// Module: classifies the operating mode and the effective operand size.
// Assumes v86_mode and long_mode are only meaningful when prot_en is 1.
// Size codes 3, and 2 outside 64-bit protected operation, map to 32-bit.
module flagpop_mode_decode
    import flagpop_pkg::*;
(
    input  logic             prot_en,
    input  logic             v86_mode,
    input  logic             long_mode,
    input  logic [1:0]       op_size,
    input  logic [CPL_W-1:0] cpl,
    output mode_e            mode,
    output opsz_e            eff_size,
    output logic             priv_top
);

    // Mode selection: protection off wins, then the virtual-8086 bit
    always_comb begin
        if (!prot_en)      mode = MODE_REAL;
        else if (v86_mode) mode = MODE_V86;
        else               mode = MODE_PROT;
    end

    // Effective size: only a 64-bit protected context may keep the 64-bit code
    always_comb begin
        if (op_size == 2'd0)
            eff_size = SZ16;
        else if (op_size == 2'd2 && long_mode && mode == MODE_PROT)
            eff_size = SZ64;
        else
            eff_size = SZ32;
    end

    // Full privilege: real-address mode, or CPL 0 in protected operation
    always_comb priv_top = (mode == MODE_REAL) || (mode == MODE_PROT && cpl == '0);

endmodule

// File: rtl/flagpop_mask_gen.sv
// Module: per-bit write enables, fault decision and VIF redirect for one pop.
// Assumes cur_iopl is the register's current IOPL field and that the
// stacked TF and IF bits are taken from the popped value.
module flagpop_mask_gen
    import flagpop_pkg::*;
(
    input  mode_e            mode,
    input  opsz_e            eff_size,
    input  logic             priv_top,
    input  logic [CPL_W-1:0] cpl,
    input  logic [1:0]       cur_iopl,
    input  logic             vme_en,
    input  logic             vint_pend,
    input  logic             stack_tf,
    input  logic             stack_if,
    output flags_t           wmask,
    output logic             fault,
    output logic             vif_load
);

    flags_t raw_mask;

    // Permission matrix: mode and privilege select which flags may load
    always_comb begin
        raw_mask = '0;
        fault    = 1'b0;
        vif_load = 1'b0;
        unique case (mode)
            MODE_REAL: raw_mask = LOADABLE_M;
            MODE_PROT: begin
                if (priv_top)
                    raw_mask = LOADABLE_M;
                else if (cpl > CPL_W'(cur_iopl))
                    raw_mask = LOADABLE_M & ~IOPL_M & ~IF_M;
                else
                    raw_mask = LOADABLE_M & ~IOPL_M;
            end
            MODE_V86: begin
                if (cur_iopl == 2'd3)
                    raw_mask = LOADABLE_M & ~IOPL_M;
                else if (eff_size != SZ16 || !vme_en)
                    fault = 1'b1;
                else if (stack_tf || (vint_pend && stack_if))
                    fault = 1'b1;
                else begin
                    raw_mask = LOADABLE_M & ~IOPL_M & ~IF_M;
                    vif_load = 1'b1;
                end
            end
            default: raw_mask = '0;
        endcase
    end

    // Size trim: a 16-bit pop reaches only the low half-word
    always_comb begin
        wmask = (eff_size == SZ16) ? (raw_mask & NARROW_M) : raw_mask;
    end

    // Guard: IOPL is never writable at nonzero CPL in protected operation
    always_comb begin
        // R5
        iopl_guard_chk: assert (!(mode == MODE_PROT && cpl != '0) ||
                                (wmask[B_IOPL+1:B_IOPL] == 2'b00));
    end

endmodule

// File: rtl/flagpop_flag_reg.sv
// Module: the flags register and the registered fault pulse.
// Assumes wmask never covers RF, VM, VIF or VIP; VIF is loaded only through
// vif_load. Non-existent bits are held at their fixed values.
module flagpop_flag_reg
    import flagpop_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pop_vld,
    input  flags_t pop_data,
    input  flags_t wmask,
    input  logic   fault,
    input  logic   vif_load,
    output flags_t flags_q,
    output logic   fault_q
);

    flags_t merged;
    flags_t nxt;

    // Merge: take enabled bits from the stack, then apply VIF and RF rules
    always_comb begin
        merged = (flags_q & ~wmask) | (pop_data & wmask);
        if (vif_load)
            merged[B_VIF] = pop_data[B_IF];
        merged[B_RF] = 1'b0;
        nxt = (merged & STATE_M) | ONES_M;
    end

    // Register: update only on an accepted, non-faulting pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= RESET_V;
        else if (pop_vld && !fault)
            flags_q <= nxt;
    end

    // Fault pulse: one cycle after a refused pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else
            fault_q <= pop_vld && fault;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_vld |=> $stable(flags_q));

    // R7
    fault_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> $stable(flags_q));

    // R12
    fault_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> $past(pop_vld));

endmodule

// File: rtl/flagpop_unit.sv
// Module: top of the stack-to-flags write permission unit.
// Assumes the caller presents mode, CPL and size with pop_vld; the flags
// and the fault pulse respond on the following clock edge.
module flagpop_unit
    import flagpop_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pop_vld,
    input  logic [FLAGS_W-1:0]  pop_data,
    input  logic [1:0]          op_size,
    input  logic                prot_en,
    input  logic                v86_mode,
    input  logic                long_mode,
    input  logic                vme_en,
    input  logic                vint_pend,
    input  logic [CPL_W-1:0]    cpl,
    output logic [FLAGS_W-1:0]  flags,
    output logic                gp_fault
);

    mode_e  mode;
    opsz_e  eff_size;
    logic   priv_top;
    flags_t wmask;
    logic   fault;
    logic   vif_load;
    flags_t flags_q;
    logic   fault_q;

    flagpop_mode_decode u_decode (
        .prot_en   (prot_en),
        .v86_mode  (v86_mode),
        .long_mode (long_mode),
        .op_size   (op_size),
        .cpl       (cpl),
        .mode      (mode),
        .eff_size  (eff_size),
        .priv_top  (priv_top)
    );

    flagpop_mask_gen u_mask (
        .mode      (mode),
        .eff_size  (eff_size),
        .priv_top  (priv_top),
        .cpl       (cpl),
        .cur_iopl  (flags_q[B_IOPL+1:B_IOPL]),
        .vme_en    (vme_en),
        .vint_pend (vint_pend),
        .stack_tf  (pop_data[B_TF]),
        .stack_if  (pop_data[B_IF]),
        .wmask     (wmask),
        .fault     (fault),
        .vif_load  (vif_load)
    );

    flagpop_flag_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_vld  (pop_vld),
        .pop_data (pop_data),
        .wmask    (wmask),
        .fault    (fault),
        .vif_load (vif_load),
        .flags_q  (flags_q),
        .fault_q  (fault_q)
    );

    // Outputs: straight from the register stage
    assign flags    = flags_q;
    assign gp_fault = fault_q;

    // R4
    narrow_keeps_ac_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_vld && op_size == 2'd0) |=>
        ({flags[B_ID], flags[B_AC]} == $past({flags[B_ID], flags[B_AC]})));

    // R9
    vif_from_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_vld && prot_en && v86_mode && vme_en && op_size == 2'd0 &&
         flags[B_IOPL+1:B_IOPL] != 2'd3 && !pop_data[B_TF] &&
         !(vint_pend && pop_data[B_IF])) |=>
        (flags[B_VIF] == $past(pop_data[B_IF])));

    // R10
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pop_vld) |-> (flags[B_ONE] && !flags[B_RF] && (flags & ~STATE_M & ~ONES_M) == '0));

endmodule

// File: tb/flagpop_unit_tb.sv
module flagpop_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pop_vld = 1'b0;
    logic [63:0] pop_data = '0;
    logic [1:0]  op_size = '0;
    logic        prot_en = 1'b0;
    logic        v86_mode = 1'b0;
    logic        long_mode = 1'b0;
    logic        vme_en = 1'b0;
    logic        vint_pend = 1'b0;
    logic [1:0]  cpl = '0;
    logic [63:0] flags;
    logic        gp_fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int cycles = 0;

    always #10 clk = ~clk;

    flagpop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pop_vld(pop_vld), .pop_data(pop_data),
        .op_size(op_size), .prot_en(prot_en), .v86_mode(v86_mode),
        .long_mode(long_mode), .vme_en(vme_en), .vint_pend(vint_pend),
        .cpl(cpl), .flags(flags), .gp_fault(gp_fault)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        pe;
        logic        v86;
        logic        lm;
        logic        vme;
        logic        vip;
        logic [1:0]  cl;
        logic [1:0]  sz;
        logic [63:0] data;
        logic [63:0] expf;
        logic        expg;
    } vec_t;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 19;
    // Chained vectors: each expectation depends on the state left by the previous one
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 2'd1, ONES,           64'h247FD7, 1'b0}, // R3 R10 real all ones
        '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 2'd0, 64'h0,          64'h240002, 1'b0}, // R4 narrow keeps AC ID
        '{4'd3,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 2'd1, 64'h1000,       64'h001002, 1'b0}, // R3 CPL0 sets IOPL=1
        '{4'd5,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 2'd1, ONES,           64'h245DD7, 1'b0}, // R5 CPL>IOPL keeps IF, IOPL
        '{4'd4,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 2'd0, 64'h0,          64'h241002, 1'b0}, // R4 narrow at CPL1
        '{4'd5,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 2'd1, 64'h200,        64'h001202, 1'b0}, // R5 CPL<=IOPL loads IF
        '{4'd11, 1'b1,1'b0,1'b1,1'b0,1'b0, 2'd0, 2'd2, ONES,           64'h247FD7, 1'b0}, // R11 64-bit pop
        '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 2'd1, 64'h0,          64'h000002, 1'b0}, // R3 clear, IOPL=0
        '{4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 2'd3, 2'd0, ONES,           64'h000002, 1'b1}, // R7 ext off
        '{4'd7,  1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3, 2'd1, 64'h0,          64'h000002, 1'b1}, // R7 32-bit
        '{4'd11, 1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3, 2'd2, 64'h0,          64'h000002, 1'b1}, // R11 64 acts as 32
        '{4'd8,  1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3, 2'd0, 64'h100,        64'h000002, 1'b1}, // R8 stacked TF
        '{4'd8,  1'b1,1'b1,1'b0,1'b1,1'b1, 2'd3, 2'd0, 64'h200,        64'h000002, 1'b1}, // R8 pending + IF
        '{4'd9,  1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3, 2'd0, 64'hFEFF,       64'h084CD7, 1'b0}, // R9 VIF set
        '{4'd9,  1'b1,1'b1,1'b0,1'b1,1'b1, 2'd3, 2'd0, 64'h0,          64'h000002, 1'b0}, // R9 VIF cleared
        '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 2'd0, 64'h3000,       64'h003002, 1'b0}, // R4 IOPL=3
        '{4'd6,  1'b1,1'b1,1'b0,1'b0,1'b0, 2'd3, 2'd1, ONES,           64'h247FD7, 1'b0}, // R6 v86 IOPL3
        '{4'd6,  1'b1,1'b1,1'b0,1'b0,1'b0, 2'd3, 2'd0, 64'h0,          64'h243002, 1'b0}, // R6 narrow keeps IOPL
        '{4'd5,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3, 2'd1, 64'h200,        64'h003202, 1'b0}  // R5 CPL3 IOPL3 loads IF
    };

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s flags actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s gp_fault actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Present one pop for one cycle; on return the registered result is visible
    task automatic do_pop(input logic pe, input logic v86, input logic lm, input logic vme,
                          input logic vip, input logic [1:0] cl, input logic [1:0] sz,
                          input logic [63:0] data);
        @(negedge clk);
        prot_en = pe; v86_mode = v86; long_mode = lm; vme_en = vme;
        vint_pend = vip; cpl = cl; op_size = sz; pop_data = data;
        pop_vld = 1'b1;
        @(negedge clk);
        pop_vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk64("R1", flags, 64'h2);
        chk1("R1", gp_fault, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_pop(VECS[i].pe, VECS[i].v86, VECS[i].lm, VECS[i].vme, VECS[i].vip,
                   VECS[i].cl, VECS[i].sz, VECS[i].data);
            chk64($sformatf("R%0d vec%0d", VECS[i].req, i), flags, VECS[i].expf);
            chk1($sformatf("R%0d vec%0d", VECS[i].req, i), gp_fault, VECS[i].expg);
        end

        // R2 idle: inputs wiggle without pop_vld, flags hold
        pop_data = ONES; prot_en = 1'b0; op_size = 2'd1;
        repeat (3) @(negedge clk);
        chk64("R2", flags, 64'h3202);
        chk1("R2", gp_fault, 1'b0);

        // R11 size code 3 acts as 32-bit: ID and AC load
        do_pop(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, ONES);
        chk64("R11", flags, 64'h247FD7);

        // R3 clear back to IOPL=0 in real mode
        do_pop(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 64'h0);
        chk64("R3", flags, 64'h2);

        // R7 and R12 fault pulse lasts one cycle
        do_pop(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, ONES);
        chk1("R7", gp_fault, 1'b1);
        chk64("R7", flags, 64'h2);
        @(negedge clk);
        chk1("R12", gp_fault, 1'b0);

        // R1 reset in mid-operation
        do_pop(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'hFFFF);
        chk64("R4", flags, 64'h7FD7);
        rst_n = 1'b0;
        @(negedge clk);
        chk64("R1", flags, 64'h2);
        chk1("R1", gp_fault, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule